// File: doc/BRIEF.md
# Rate-Calibrated Seconds Divider

This block divides a 32,768 Hz oscillator clock down to a one-pulse-per-second tick and trims the long-term rate digitally rather than with analog trimming. The divider is built as a fast stage of 256 input cycles followed by a slow stage of 128 fast-stage periods. Rate correction is applied at the fast stage. In a correcting second, one extra fast-stage pulse is inserted to advance the count. Otherwise, half a fast-stage period of input pulses is swallowed to retard it.

Correction runs over a repeating window of 64 minutes. A 5-bit magnitude N and a direction bit are captured at the start of each window. In each of the first 2N minutes of that window, only the opening second is corrected. With N at its maximum of 31, minutes 0 to 61 are corrected and the final two minutes of the window never are. One step of N moves the rate by roughly +4.07 ppm when speeding up, or by roughly -2.03 ppm when slowing down.

A separate free-running output at 1/64 of the input rate (512 Hz nominal) lets a tester measure the raw oscillator. This output is never touched by the calibration. All widths and counts are parameters, so the same block can be built with a shortened divider for test.

Top module: `rtc_cal_divider`

## Requirements
- R1: While `rst_n` is low, `tick_o` and `test_o` are 0. After release, the first `tick_o` arrives DIV_LO*DIV_HI input cycles after the first rising clock edge.
- R2: With the captured magnitude at 0, every second lasts exactly DIV_LO*DIV_HI input cycles, for either value of `cal_up`.
- R3: With `cal_up`=1 and captured magnitude N, the opening second of each of minutes 0 to 2N-1 of the window lasts DIV_LO*(DIV_HI-1) input cycles, one fast-stage period less than nominal.
- R4: With `cal_up`=0 and captured magnitude N, the opening second of each of minutes 0 to 2N-1 of the window lasts DIV_LO*DIV_HI + DIV_LO/2 input cycles.
- R5: Seconds other than second 0 of a minute are always nominal, and every second of minutes 2N and above in the window is also nominal.
- R6: The count of corrected minutes is limited to MIN_PER_CYC-2, so the last two minutes of every window are always nominal, however large N is.
- R7: `cal_mag` and `cal_up` are captured on the first clock after reset and again on the last clock of each window. Changes at any other time have no effect until the next window.
- R8: `test_o` starts at 0 and inverts every TEST_DIV/2 input cycles from the first clock after reset, whatever the calibration setting.
- R9: `tick_o` is high for exactly one input cycle: the last cycle of each second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock (32,768 Hz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_mag | input | MAG_W | Calibration magnitude N |
| cal_up | input | 1 | Direction: 1 speeds the clock up, 0 slows it down |
| tick_o | output | 1 | One-cycle pulse ending each corrected second |
| test_o | output | 1 | Uncorrected square wave at input/TEST_DIV |

## Verification
The divider is run with a shortened build through a series of windows. Each window uses a different setting: zero magnitude with each direction, a small magnitude in each direction, and the maximum magnitude in each direction.

- Zero magnitude separates a correct idle divider from one that corrects anyway.
- Small magnitudes show whether correction stops exactly at minute 2N and touches only second 0.
- The maximum magnitude exercises the limit that keeps the last two minutes clean.

Every window also changes the inputs twice partway through, first to unrelated values. Each second's length is then compared against the values captured at the window start, so a design that picks up changes early gives wrong second lengths.

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider #(
  parameter int DIV_LO      = 256,
  parameter int DIV_HI      = 128,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64,
  parameter int MAG_W       = 5,
  parameter int TEST_DIV    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_up,
  output logic             tick_o,
  output logic             test_o
);
  localparam int BLANK   = DIV_LO / 2;
  localparam int MOD_CAP = MIN_PER_CYC - 2;
  localparam int LO_W    = $clog2(DIV_LO + BLANK);
  localparam int HI_W    = $clog2(DIV_HI);
  localparam int SEC_W   = $clog2(SEC_PER_MIN);
  localparam int MIN_W   = $clog2(MIN_PER_CYC);
  localparam int TST_W   = $clog2(TEST_DIV);

  logic [LO_W-1:0]  lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic [TST_W-1:0] tst_q;
  logic [MAG_W-1:0] mag_q;
  logic             up_q, armed_q;
  logic             mod_min, mod_sec, lo_last, hi_last;
  logic             sec_last, min_last, cyc_end;
  logic [MAG_W:0]   twice;

  assign twice = {mag_q, 1'b0};

  always_comb begin
    if (int'(twice) > MOD_CAP) mod_min = int'(min_q) < MOD_CAP;
    else                       mod_min = int'(min_q) < int'(twice);
  end

  assign mod_sec  = mod_min && (sec_q == '0);
  assign lo_last  = (mod_sec && !up_q && hi_q == '0) ? (lo_q == LO_W'(DIV_LO + BLANK - 1))
                                                      : (lo_q == LO_W'(DIV_LO - 1));
  assign hi_last  = (mod_sec && up_q) ? (hi_q == HI_W'(DIV_HI - 2))
                                      : (hi_q == HI_W'(DIV_HI - 1));
  assign tick_o   = lo_last && hi_last;
  assign sec_last = sec_q == SEC_W'(SEC_PER_MIN - 1);
  assign min_last = min_q == MIN_W'(MIN_PER_CYC - 1);
  assign cyc_end  = tick_o && sec_last && min_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      sec_q <= '0;
      min_q <= '0;
    end else begin
      lo_q <= lo_last ? '0 : lo_q + LO_W'(1);
      if (lo_last) hi_q <= hi_last ? '0 : hi_q + HI_W'(1);
      if (tick_o) begin
        sec_q <= sec_last ? '0 : sec_q + SEC_W'(1);
        if (sec_last) min_q <= min_last ? '0 : min_q + MIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mag_q   <= '0;
      up_q    <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (!armed_q || cyc_end) begin
        mag_q <= cal_mag;
        up_q  <= cal_up;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tst_q  <= '0;
      test_o <= 1'b0;
    end else if (tst_q == TST_W'(TEST_DIV / 2 - 1)) begin
      tst_q  <= '0;
      test_o <= ~test_o;
    end else begin
      tst_q <= tst_q + TST_W'(1);
    end
  end
endmodule

// File: rtl/rtc_cal_divider_chk.sv
module rtc_cal_divider_chk #(
  parameter int DIV_LO   = 256,
  parameter int DIV_HI   = 128,
  parameter int MAG_W    = 5,
  parameter int TEST_DIV = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_o,
  input logic             test_o,
  input logic [MAG_W-1:0] mag_q,
  input logic             up_q,
  input logic             armed_q,
  input logic             cyc_end
);
  localparam int NOM  = DIV_LO * DIV_HI;
  localparam int FAST = DIV_LO * (DIV_HI - 1);
  localparam int SLOW = DIV_LO * DIV_HI + DIV_LO / 2;
  localparam int HALF = TEST_DIV / 2;

  int unsigned run_len, edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 0;
      edges   <= 0;
    end else begin
      run_len <= tick_o ? 0 : run_len + 1;
      edges   <= edges + 1;
    end
  end

  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  assert_second_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (run_len + 1 == NOM || run_len + 1 == FAST || run_len + 1 == SLOW));

  assert_hold_setting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !cyc_end) |=> ($stable(mag_q) && $stable(up_q)));

  assert_test_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    test_o == ((edges % (2 * HALF)) >= HALF));
endmodule

bind rtc_cal_divider rtc_cal_divider_chk #(
  .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .MAG_W(MAG_W), .TEST_DIV(TEST_DIV)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_o(tick_o), .test_o(test_o),
  .mag_q(mag_q), .up_q(up_q), .armed_q(armed_q), .cyc_end(cyc_end)
);

// File: tb/rtc_cal_divider_tb_top.sv
module rtc_cal_divider_tb_top;
  localparam int LO = 8, HI = 4, SPM = 3, MPC = 8, MW = 5, TD = 8;
  localparam int NOM  = LO * HI;
  localparam int FAST = LO * (HI - 1);
  localparam int SLOW = LO * HI + LO / 2;
  localparam int SPC  = SPM * MPC;
  localparam int NCFG = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic [MW-1:0] mag;
  logic up;
  logic tick, tst;

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  int ticks = 0;
  int since = 1;
  int pos = 0;
  bit prev_tick = 1'b0;
  bit ended = 1'b0;
  int cm[NCFG] = '{0, 0, 2, 3, 31, 31, 1};
  bit cu[NCFG] = '{1, 0, 1, 0, 1, 0, 1};

  always #10 clk = ~clk;

  rtc_cal_divider #(
    .DIV_LO(LO), .DIV_HI(HI), .SEC_PER_MIN(SPM),
    .MIN_PER_CYC(MPC), .MAG_W(MW), .TEST_DIV(TD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cal_mag(mag), .cal_up(up),
    .tick_o(tick), .test_o(tst)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic push_cycle(input int idx);
    int lim;
    lim = 2 * cm[idx];
    if (lim > MPC - 2) lim = MPC - 2;
    for (int mi = 0; mi < MPC; mi++) begin
      for (int s = 0; s < SPM; s++) begin
        string t;
        if (s == 0 && mi < lim) begin
          exp_q.push_back(cu[idx] ? FAST : SLOW);
          t = cu[idx] ? "R3" : "R4";
        end else begin
          exp_q.push_back(NOM);
          if (cm[idx] == 0) t = "R2";
          else if (mi >= MPC - 2 && 2 * cm[idx] > MPC - 2) t = "R6";
          else t = "R5";
        end
        if (idx == 0 && mi == 0 && s == 0) t = {t, "/R1"};
        if (idx > 0 && s == 0) t = {t, "/R7"};
        tag_q.push_back(t);
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst_n === 1'b1) begin
      pos++;
      since++;
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !ended) begin
      check(tst == (((pos / (TD / 2)) % 2) == 1), "R8", "test output level",
            int'(tst), (pos / (TD / 2)) % 2);
      if (tick) begin
        check(!prev_tick, "R9", "tick width", int'(prev_tick) + 1, 1);
        ticks++;
        if (exp_q.size() > 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(since == e, t, "second length", since, e);
        end else begin
          check(1'b0, "R2", "unexpected tick", ticks, 0);
        end
        since = 0;
      end
      prev_tick = tick;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R2", "watchdog, seconds still pending", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    mag   = MW'(cm[0]);
    up    = cu[0];
    for (int i = 0; i < NCFG; i++) push_cycle(i);
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1", "tick in reset", int'(tick), 0);
    check(tst == 1'b0, "R1", "test output in reset", int'(tst), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < NCFG - 1; i++) begin
      while (ticks < i * SPC + 1) @(negedge clk);
      mag = MW'(cm[i + 1] ^ 17);
      up  = ~cu[i + 1];
      while (ticks < i * SPC + 10) @(negedge clk);
      mag = MW'(cm[i + 1]);
      up  = cu[i + 1];
    end
    while (exp_q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule